// File: doc/BRIEF.md
# Memory-mapped UART word bridge

This block sits between a 32-bit processor memory bus and a byte-wide UART link. The bus side is a single device port: the processor issues a read or a write to the block's address and then waits while `busy` is high. A write is cut into bytes, and the bytes are handed to the serializer one at a time. A read gathers bytes from the deserializer into a word.

Transmit handoffs are spaced by a programmable cycle count, so the serializer always finishes a frame before it is offered the next byte. On the receive side, a word normally takes four bytes. A line-feed byte (0x0A) ends it early, which lets software read a single typed character followed by Enter.

The block keeps only one request in flight. A read that arrives during a write waits for the write to finish, and the processor sees one continuous stall. Bytes that arrive while no read is waiting are discarded.

Top module: `uart_word_bridge`

## Requirements
- R1: A write to `DEV_ADDR` hands the four bytes of `wr_data` to the transmitter least significant byte first. Each byte is a one-cycle `tx_valid` pulse with the byte on `tx_value`.
- R2: The first byte of a write appears in the second cycle after the request is sampled, once the gap from any earlier byte has run out. Consecutive `tx_valid` pulses are exactly `TX_GAP` cycles apart within a word, and never closer than `TX_GAP` across words.
- R3: After an accepted write, `busy` is high from the next cycle. It falls in the cycle that the fourth byte is presented on `tx_valid`.
- R4: After an accepted read, `busy` is high from the next cycle. Received bytes fill the word starting at bits 7:0, and the fourth byte completes it.
- R5: A received 0x0A byte completes the word early. The line feed is not stored, and lanes above the bytes already received read as zero (a line feed as the first byte yields 0).
- R6: `busy` falls in the same cycle that `rd_data` shows the completed word. `rd_data` holds that value until a later read completes, and writes do not change it.
- R7: `rx_valid` bytes are discarded when no read is armed. This includes bytes sampled in the same cycle as the read request.
- R8: A read requested together with a write, or during one, waits for the write. `busy` stays high without a gap, and the read is armed from the cycle after the last byte is handed off.
- R9: Requests whose address differs from `DEV_ADDR` have no effect: `busy` stays low and no `tx_valid` pulse occurs.
- R10: While `rst` is high, and in the first cycle after it, `busy` and `tx_valid` are low and `rd_data` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 1 | Read request strobe |
| rd_addr | input | ADDR_W | Read address |
| wr_en | input | 1 | Write request strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Word to transmit |
| rd_data | output | DATA_W | Last completed received word |
| busy | output | 1 | High while a request is being served |
| tx_value | output | BYTE_W | Byte offered to the serializer |
| tx_valid | output | 1 | One-cycle handoff strobe for `tx_value` |
| rx_value | input | BYTE_W | Byte from the deserializer |
| rx_valid | input | 1 | One-cycle strobe for `rx_value` |

## Verification
The bench builds the block with `TX_GAP` set to 5 and `DEV_ADDR` set to 0x4000_0010, with default 32-bit words and 8-bit bytes. The short gap allows exact checks of byte spacing, both inside a word and between back-to-back writes, in a few cycles. The non-zero address makes an off-address request a distinct case. With four lanes, random reads cover every early line-feed position, and they are mixed with stray bytes, reads issued together with writes, and a line feed as the first byte.

// File: rtl/uwb_pkg.sv
package uwb_pkg;

  // Bridge service state: one request in flight at a time.
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WRITE = 2'd1,
    ST_READ  = 2'd2
  } bridge_state_t;

  // Byte value that closes a received word early.
  localparam logic [7:0] LINE_FEED = 8'h0A;

endpackage

// File: rtl/uwb_tx_packer.sv
module uwb_tx_packer #(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8,
  parameter int TX_GAP = 8680
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [DATA_W-1:0] word,
  output logic              ready,
  output logic              done,
  output logic [BYTE_W-1:0] tx_value,
  output logic              tx_valid
);

  localparam int LANES = DATA_W / BYTE_W;
  localparam int CNT_W = $clog2(LANES + 1);
  localparam int GAP_W = (TX_GAP > 1) ? $clog2(TX_GAP) : 1;

  logic [DATA_W-1:0] shift_q;
  logic [CNT_W-1:0]  left_q;
  logic [GAP_W-1:0]  gap_q;
  logic              emit;

  // A byte leaves when one is pending and the spacing counter has drained.
  assign emit  = (left_q != '0) && (gap_q == '0);
  assign done  = emit && (left_q == CNT_W'(1));
  assign ready = (left_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      shift_q  <= '0;
      left_q   <= '0;
      gap_q    <= '0;
      tx_value <= '0;
      tx_valid <= 1'b0;
    end else begin
      tx_valid <= emit;
      if (emit) begin
        tx_value <= shift_q[BYTE_W-1:0];
        shift_q  <= shift_q >> BYTE_W;
        left_q   <= left_q - CNT_W'(1);
        gap_q    <= GAP_W'(TX_GAP - 1);
      end else if (gap_q != '0) begin
        gap_q <= gap_q - GAP_W'(1);
      end
      if (start && ready) begin
        shift_q <= word;
        left_q  <= CNT_W'(LANES);
      end
    end
  end

endmodule

// File: rtl/uwb_rx_gather.sv
module uwb_rx_gather #(
  parameter int              DATA_W  = 32,
  parameter int              BYTE_W  = 8,
  parameter logic [BYTE_W-1:0] NL_CODE = 8'h0A
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              arm,
  input  logic              enable,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_value,
  output logic              done,
  output logic [DATA_W-1:0] word
);

  localparam int LANES = DATA_W / BYTE_W;
  localparam int IDX_W = (LANES > 1) ? $clog2(LANES) : 1;

  logic [DATA_W-1:0] acc_q;
  logic [IDX_W-1:0]  idx_q;
  logic              hit, is_nl, take, last;

  assign hit   = enable && rx_valid;
  assign is_nl = (rx_value == NL_CODE);
  assign take  = hit && !is_nl;
  assign last  = (idx_q == IDX_W'(LANES - 1));
  assign done  = hit && (is_nl || last);

  // Merge the incoming byte into its lane; other lanes keep the accumulator.
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign word[g*BYTE_W +: BYTE_W] =
      (take && (idx_q == IDX_W'(g))) ? rx_value : acc_q[g*BYTE_W +: BYTE_W];
  end

  always_ff @(posedge clk) begin
    if (rst || arm) begin
      acc_q <= '0;
      idx_q <= '0;
    end else if (take && !done) begin
      acc_q <= word;
      idx_q <= idx_q + IDX_W'(1);
    end
  end

endmodule

// File: rtl/uart_word_bridge.sv
module uart_word_bridge #(
  parameter int                ADDR_W   = 32,
  parameter int                DATA_W   = 32,
  parameter int                BYTE_W   = 8,
  parameter logic [ADDR_W-1:0] DEV_ADDR = 32'h4000_0000,
  parameter int                TX_GAP   = 8680
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              busy,
  output logic [BYTE_W-1:0] tx_value,
  output logic              tx_valid,
  input  logic [BYTE_W-1:0] rx_value,
  input  logic              rx_valid
);

  import uwb_pkg::*;

  bridge_state_t     state_q, state_n;
  logic              pend_q, pend_n;
  logic              wr_hit, rd_hit;
  logic              tx_start, tx_ready, tx_done;
  logic              rx_arm, rx_done;
  logic [DATA_W-1:0] rx_word;

  assign wr_hit = wr_en && (wr_addr == DEV_ADDR);
  assign rd_hit = rd_en && (rd_addr == DEV_ADDR);

  uwb_tx_packer #(
    .DATA_W (DATA_W),
    .BYTE_W (BYTE_W),
    .TX_GAP (TX_GAP)
  ) tx_i (
    .clk      (clk),
    .rst      (rst),
    .start    (tx_start),
    .word     (wr_data),
    .ready    (tx_ready),
    .done     (tx_done),
    .tx_value (tx_value),
    .tx_valid (tx_valid)
  );

  uwb_rx_gather #(
    .DATA_W  (DATA_W),
    .BYTE_W  (BYTE_W),
    .NL_CODE (BYTE_W'(LINE_FEED))
  ) rx_i (
    .clk      (clk),
    .rst      (rst),
    .arm      (rx_arm),
    .enable   (state_q == ST_READ),
    .rx_valid (rx_valid),
    .rx_value (rx_value),
    .done     (rx_done),
    .word     (rx_word)
  );

  always_comb begin
    state_n  = state_q;
    pend_n   = pend_q;
    tx_start = 1'b0;
    rx_arm   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (wr_hit && tx_ready) begin
          state_n  = ST_WRITE;
          tx_start = 1'b1;
          pend_n   = rd_hit;
        end else if (rd_hit) begin
          state_n = ST_READ;
          rx_arm  = 1'b1;
        end
      end
      ST_WRITE: begin
        if (rd_hit) pend_n = 1'b1;
        if (tx_done) begin
          pend_n = 1'b0;
          if (pend_q || rd_hit) begin
            state_n = ST_READ;
            rx_arm  = 1'b1;
          end else begin
            state_n = ST_IDLE;
          end
        end
      end
      ST_READ: begin
        if (rx_done) state_n = ST_IDLE;
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      pend_q  <= 1'b0;
      busy    <= 1'b0;
      rd_data <= '0;
    end else begin
      state_q <= state_n;
      pend_q  <= pend_n;
      busy    <= (state_n != ST_IDLE);
      if (state_q == ST_READ && rx_done) rd_data <= rx_word;
    end
  end

endmodule

// File: rtl/uwb_bridge_checker.sv
module uwb_bridge_checker #(
  parameter int                ADDR_W   = 32,
  parameter int                DATA_W   = 32,
  parameter logic [ADDR_W-1:0] DEV_ADDR = 32'h4000_0000,
  parameter int                TX_GAP   = 8680
) (
  input logic              clk,
  input logic              rst,
  input logic              rd_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] rd_data,
  input logic              busy,
  input logic              tx_valid
);

  logic [31:0] since_q;
  logic        any_hit;

  assign any_hit = (rd_en && (rd_addr == DEV_ADDR)) || (wr_en && (wr_addr == DEV_ADDR));

  // Cycles since the previous handoff pulse, saturating at TX_GAP.
  always_ff @(posedge clk) begin
    if (rst) since_q <= 32'(TX_GAP);
    else if (tx_valid) since_q <= 32'd1;
    else if (since_q < 32'(TX_GAP)) since_q <= since_q + 32'd1;
  end

  a_r2_tx_spacing: assert property (@(posedge clk) disable iff (rst)
    tx_valid |-> (since_q >= 32'(TX_GAP)));

  // R3: a handoff outside busy is only the final byte, as busy falls.
  a_r3_last_byte_release: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !busy) |-> $fell(busy));

  a_r6_rd_data_hold: assert property (@(posedge clk) disable iff (rst)
    !$fell(busy) |-> $stable(rd_data));

  a_r9_busy_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(any_hit));

endmodule

bind uart_word_bridge uwb_bridge_checker #(
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W),
  .DEV_ADDR (DEV_ADDR),
  .TX_GAP   (TX_GAP)
) chk_i (
  .clk      (clk),
  .rst      (rst),
  .rd_en    (rd_en),
  .rd_addr  (rd_addr),
  .wr_en    (wr_en),
  .wr_addr  (wr_addr),
  .rd_data  (rd_data),
  .busy     (busy),
  .tx_valid (tx_valid)
);

// File: tb/uart_word_bridge_tb.sv
`timescale 1ns/1ps
module uart_word_bridge_tb_top;

  localparam int          G   = 5;
  localparam logic [31:0] DEV = 32'h4000_0010;
  localparam logic [7:0]  LF  = 8'h0A;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rd_en = 1'b0, wr_en = 1'b0, rx_valid = 1'b0;
  logic [31:0] rd_addr = '0, wr_addr = '0, wr_data = '0;
  logic [7:0]  rx_value = '0;
  logic [31:0] rd_data;
  logic        busy, tx_valid;
  logic [7:0]  tx_value;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  uart_word_bridge #(
    .ADDR_W(32), .DATA_W(32), .BYTE_W(8), .DEV_ADDR(DEV), .TX_GAP(G)
  ) dut_i (
    .clk(clk), .rst(rst), .rd_en(rd_en), .rd_addr(rd_addr), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_data(rd_data), .busy(busy),
    .tx_value(tx_value), .tx_valid(tx_valid), .rx_value(rx_value), .rx_valid(rx_valid)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  function automatic logic [31:0] exp_word(input logic [7:0] b [4], input int n);
    logic [31:0] w = '0;
    for (int i = 0; i < n; i++) begin
      if (b[i] == LF) break;
      w[8*i +: 8] = b[i];
    end
    return w;
  endfunction

  function automatic logic [7:0] rand_data();
    logic [7:0] r = 8'($urandom);
    if (r == LF) r = 8'h0B;
    return r;
  endfunction

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Called at a negedge. first: cycle index of the first expected byte.
  task automatic do_write(input logic [31:0] w, input bit with_rd, input int first);
    int nb = 0;
    bit held = 1;
    int lim = first + 3*G;
    wr_en = 1; wr_addr = DEV; wr_data = w; rd_en = with_rd; rd_addr = DEV;
    @(negedge clk);
    wr_en = 0; rd_en = 0;
    chk(busy === 1'b1, "R3 busy after write", 32'(busy), 1);
    for (int t = 2; t <= lim; t++) begin
      @(negedge clk);
      if (tx_valid) begin
        chk(t == first + nb*G, "R2 byte timing", 32'(t), 32'(first + nb*G));
        if (nb < 4) chk(tx_value === w[8*nb +: 8], "R1 byte order", 32'(tx_value), 32'(w[8*nb +: 8]));
        nb++;
      end
      if (t < lim && busy !== 1'b1) held = 0;
    end
    chk(nb == 4, "R1 byte count", 32'(nb), 4);
    chk(held, "R3 busy held during write", 32'(held), 1);
    if (with_rd) chk(busy === 1'b1, "R8 busy continuous into read", 32'(busy), 1);
    else chk(busy === 1'b0, "R3 busy falls with last byte", 32'(busy), 0);
  endtask

  // Called at a negedge. issue=0 continues a read that was queued behind a write.
  task automatic do_read(input bit issue, input logic [7:0] b [4], input int n, input bit junk);
    logic [31:0] exp = exp_word(b, n);
    if (issue) begin
      rd_en = 1; rd_addr = DEV;
      if (junk) begin rx_valid = 1; rx_value = 8'hEE; end
      @(negedge clk);
      rd_en = 0; rx_valid = 0;
      chk(busy === 1'b1, "R4 busy after read", 32'(busy), 1);
    end
    for (int i = 0; i < n; i++) begin
      idle($urandom_range(0, 3));
      rx_valid = 1; rx_value = b[i];
      @(negedge clk);
      rx_valid = 0;
      if (i < n-1) chk(busy === 1'b1, "R4 busy until word done", 32'(busy), 1);
    end
    chk(busy === 1'b0, "R6 busy falls with data", 32'(busy), 0);
    chk(rd_data === exp, (n < 4 || b[3] == LF) ? "R5 early line feed word" : "R4 assembled word", rd_data, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] b [4];
    logic [31:0] w, held;
    int n, k, seen;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(busy === 1'b0 && tx_valid === 1'b0 && rd_data === '0, "R10 reset state", {busy, tx_valid, rd_data[29:0]}, 0);
    rst = 0;
    @(negedge clk);
    chk(busy === 1'b0 && tx_valid === 1'b0 && rd_data === '0, "R10 after reset", {busy, tx_valid, rd_data[29:0]}, 0);

    // Directed writes, then random writes.
    idle(G+2); do_write(32'h4433_2211, 0, 2);
    idle(G+2); do_write(32'hFF00_A55A, 0, 2);
    // R2: a back-to-back write keeps exactly TX_GAP from the previous last byte.
    do_write(32'h0A0B_0C0D, 0, G);
    for (int i = 0; i < 12; i++) begin
      idle(G + $urandom_range(0, 4));
      do_write($urandom, 0, 2);
    end

    // R9: off-address requests.
    idle(G+2);
    held = rd_data;
    wr_en = 1; wr_addr = DEV ^ 32'h4; wr_data = 32'h1234_5678;
    rd_en = 1; rd_addr = DEV + 32'h100;
    @(negedge clk); wr_en = 0; rd_en = 0;
    seen = 0;
    for (int t = 0; t < 3*G; t++) begin
      @(negedge clk);
      if (tx_valid || busy) seen++;
    end
    chk(seen == 0, "R9 off-address ignored", 32'(seen), 0);

    // R5: line feed at every position, including first.
    for (int p = 0; p < 4; p++) begin
      for (int i = 0; i < 4; i++) b[i] = rand_data();
      b[p] = LF;
      idle(2); do_read(1, b, p+1, 0);
    end

    // R7: stray bytes while idle and in the request cycle are discarded.
    for (int i = 0; i < 3; i++) begin
      rx_valid = 1; rx_value = rand_data(); @(negedge clk); rx_valid = 0;
    end
    b[0] = 8'h31; b[1] = 8'h32; b[2] = 8'h33; b[3] = 8'h34;
    do_read(1, b, 4, 1);
    chk(rd_data === 32'h3433_3231, "R7 stray bytes dropped", rd_data, 32'h3433_3231);

    // R6: rd_data survives a write and idle time.
    held = rd_data;
    idle(G+2); do_write(32'hDEAD_BEEF, 0, 2);
    idle(4);
    chk(rd_data === held, "R6 rd_data held", rd_data, held);

    // R8: read issued together with a write; bytes during the write are dropped.
    idle(G+2);
    do_write(32'hCAFE_F00D, 1, 2);
    for (int i = 0; i < 4; i++) b[i] = rand_data();
    do_read(0, b, 4, 0);
    chk(rd_data === exp_word(b, 4), "R8 queued read result", rd_data, exp_word(b, 4));

    // Random reads with random termination.
    for (int r = 0; r < 16; r++) begin
      k = $urandom_range(0, 4);
      for (int i = 0; i < 4; i++) b[i] = rand_data();
      if (k < 4) begin b[k] = LF; n = k + 1; end else n = 4;
      idle($urandom_range(1, 3));
      do_read(1, b, n, r[0]);
    end

    // Interleaved random write/read.
    for (int r = 0; r < 6; r++) begin
      idle(G+2);
      w = $urandom;
      do_write(w, 0, 2);
      for (int i = 0; i < 4; i++) b[i] = rand_data();
      do_read(1, b, 4, 0);
    end

    idle(4);
    finish_run();
  end

endmodule